// File: doc/BRIEF.md
# Multi-Context Configuration Store

This block holds the configuration of one word-level processing element in four complete copies, called contexts. One context is active at a time and drives the element's configuration outputs. A host loads words over a configuration bus that all elements share. Each write is two 32-bit transfers: first an address word that names the element, the context and the word offset, then the data word. Only the element whose identifier matches the address word accepts the data word that follows. The bus cannot read anything back.

Writes go into idle contexts while the active context keeps driving computation. A separate select input changes the active context at the next clock edge, and nothing is reloaded when it does. The element's small data register file has one bank per context. Reads and writes use the bank of the active context, so values stored under one context are still there after a switch away and back. A write aimed at the active context is refused and raises a sticky error flag.

Top module: `ctx_config_store`

## Requirements
- R1: After reset the active context is 0, `cfg_err` is 0, every word of `cfg_out` is zero and every register-file entry reads zero.
- R2: A transfer with `cfg_addr_phase`=1 whose bits [31:24] equal `PE_ID` arms a write. Bits [23:22] give the context and bits [21:0] give the word offset. The next transfer with `cfg_addr_phase`=0 stores its word at that offset of that context, as long as that context is not the active one. Word k of the active context appears on `cfg_out[32k+31:32k]`.
- R3: When the identifier in an address word differs from `PE_ID`, the data word that follows changes no stored word.
- R4: A data word with no armed address is dropped. Each address word arms exactly one data word, so a second data word in a row is dropped.
- R5: A data word whose armed offset is `DEPTH` or more is dropped and does not set `cfg_err`.
- R6: A data word whose armed context equals the active context is dropped. It sets `cfg_err`, which stays at 1 until reset.
- R7: A cycle with `ctx_sel_valid`=1 makes `ctx_sel` the active context from the next clock edge. From then on `cfg_out` shows that context's stored words.
- R8: A data word that arrives in the same cycle as a switch to the context it targets is still stored. The refusal check uses the context that was active before that edge.
- R9: The register file has one bank per context. `rf_we` writes, and `rf_rdata` reads, the entry `rf_addr` of the active context's bank. A value stays in its bank across switches to other contexts.
- R10: A new address word replaces an armed address that has not yet been used, so the data word goes to the latest target only.
- R11: While no context switch is requested, `cfg_out` does not change, whatever is written into idle contexts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_valid | input | 1 | A configuration bus transfer is present this cycle |
| cfg_addr_phase | input | 1 | 1: the transfer is an address word; 0: it is a data word |
| cfg_word | input | 32 | Configuration bus word |
| ctx_sel_valid | input | 1 | Context switch request |
| ctx_sel | input | 2 | Context to make active |
| rf_we | input | 1 | Register-file write enable (active bank) |
| rf_addr | input | 2 | Register-file entry |
| rf_wdata | input | 32 | Register-file write data |
| rf_rdata | output | 32 | Register-file read data from the active bank |
| active_ctx | output | 2 | Currently active context |
| cfg_err | output | 1 | Sticky flag: a write aimed at the active context was refused |
| cfg_out | output | DEPTH*32 | All words of the active context, word k at bits [32k+31:32k] |

## Verification
The assertions assume that `cfg_valid`, `cfg_addr_phase`, `ctx_sel_valid` and `rf_we` are known values in every cycle after reset. They also assume that the register-file bank and entry are not changed in the cycle straight after a write that is being checked. The stimulus drives every input to a defined value during reset and from then on changes inputs only on the falling clock edge. It returns the valid strobes to 0 after each transfer, so each transfer lasts exactly one rising edge. The bench runs the two-word protocol as back-to-back address and data pairs. It also sends deliberate protocol faults: orphan data words, repeated address words, foreign identifiers and out-of-range offsets. These come one at a time, so each refusal can be traced to a single transfer.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;
  localparam int BUS_W      = 32;
  localparam int ID_W       = 8;
  localparam int CTX_W      = 2;
  localparam int NUM_CTX    = 1 << CTX_W;
  localparam int OFF_W      = BUS_W - ID_W - CTX_W;

  typedef logic [CTX_W-1:0] ctx_t;

  typedef struct packed {
    logic [ID_W-1:0]  pe;
    ctx_t             ctx;
    logic [OFF_W-1:0] off;
  } cfg_target_t;
endpackage

// File: rtl/cfgstore_bus_fsm.sv
module cfgstore_bus_fsm
  import cfgstore_pkg::*;
#(
  parameter logic [ID_W-1:0] PE_ID = 8'h05,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_is_addr,
  input  logic [BUS_W-1:0] bus_word,
  input  ctx_t             active_ctx,
  output logic             wr_en,
  output ctx_t             wr_ctx,
  output logic [IDX_W-1:0] wr_idx,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_refused
);
  cfg_target_t      tgt;
  logic             armed_q, armed_d;
  ctx_t             ctx_q, ctx_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             data_beat, fire, in_range, hits_active;

  assign tgt       = cfg_target_t'(bus_word);
  assign data_beat = bus_valid && !bus_is_addr;

  always_comb begin
    armed_d = armed_q;
    ctx_d   = ctx_q;
    off_d   = off_q;
    if (bus_valid) begin
      if (bus_is_addr) begin
        armed_d = (tgt.pe == PE_ID);
        ctx_d   = tgt.ctx;
        off_d   = tgt.off;
      end else begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ctx_q   <= '0;
      off_q   <= '0;
    end else begin
      armed_q <= armed_d;
      ctx_q   <= ctx_d;
      off_q   <= off_d;
    end
  end

  assign fire        = data_beat && armed_q;
  assign in_range    = off_q < OFF_W'(DEPTH);
  assign hits_active = (ctx_q == active_ctx);
  assign wr_en       = fire && in_range && !hits_active;
  assign wr_refused  = fire && hits_active;
  assign wr_ctx      = ctx_q;
  assign wr_idx      = off_q[IDX_W-1:0];
  assign wr_data     = bus_word;

  // R4: a data beat always consumes or discards the armed address
  p_data_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_beat |=> !armed_q);
endmodule

// File: rtl/cfgstore_ctx_ctrl.sv
module cfgstore_ctx_ctrl
  import cfgstore_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_valid,
  input  ctx_t sel_ctx,
  input  logic refused,
  output ctx_t active_ctx,
  output logic err
);
  ctx_t act_q, act_d;
  logic err_q, err_d;

  always_comb begin
    act_d = act_q;
    err_d = err_q;
    if (sel_valid) act_d = sel_ctx;
    if (refused)   err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      err_q <= 1'b0;
    end else begin
      act_q <= act_d;
      err_q <= err_d;
    end
  end

  assign active_ctx = act_q;
  assign err        = err_q;

  p_switch_next_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> active_ctx == $past(sel_ctx));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/cfgstore_layers.sv
module cfgstore_layers
  import cfgstore_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  ctx_t                   wr_ctx,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [BUS_W-1:0]       wr_data,
  input  ctx_t                   active_ctx,
  output logic [DEPTH*BUS_W-1:0] cfg_flat
);
  logic [DEPTH*BUS_W-1:0] layer_flat [NUM_CTX];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [BUS_W-1:0] mem_q [DEPTH];
    logic [BUS_W-1:0] mem_d [DEPTH];
    logic             ctx_we;

    assign ctx_we = wr_en && (wr_ctx == ctx_t'(c));

    always_comb begin
      for (int w = 0; w < DEPTH; w++) mem_d[w] = mem_q[w];
      if (ctx_we) mem_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
      end else if (ctx_we) begin
        for (int w = 0; w < DEPTH; w++) mem_q[w] <= mem_d[w];
      end
    end

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
      assign layer_flat[c][w*BUS_W +: BUS_W] = mem_q[w];
    end
  end

  assign cfg_flat = layer_flat[active_ctx];

  // R6: storage never accepts a write into the context driving computation
  p_no_active_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_ctx != active_ctx);
endmodule

// File: rtl/cfgstore_rf_bank.sv
module cfgstore_rf_bank
  import cfgstore_pkg::*;
#(
  parameter int RF_DEPTH = 4,
  localparam int RF_AW = (RF_DEPTH > 1) ? $clog2(RF_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctx_t             bank,
  input  logic             we,
  input  logic [RF_AW-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] rd_bank [NUM_CTX];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_bank
    logic [BUS_W-1:0] rf_q [RF_DEPTH];
    logic             bank_we;

    assign bank_we    = we && (bank == ctx_t'(c));
    assign rd_bank[c] = rf_q[addr];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int a = 0; a < RF_DEPTH; a++) rf_q[a] <= '0;
      end else if (bank_we) begin
        rf_q[addr] <= wdata;
      end
    end
  end

  assign rdata = rd_bank[bank];

  p_rf_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we ##1 (addr == $past(addr) && bank == $past(bank)) |-> rdata == $past(wdata));
endmodule

// File: rtl/ctx_config_store.sv
module ctx_config_store
  import cfgstore_pkg::*;
#(
  parameter logic [7:0] PE_ID = 8'h05,
  parameter int DEPTH = 8,
  parameter int RF_DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RF_AW = (RF_DEPTH > 1) ? $clog2(RF_DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_valid,
  input  logic                   cfg_addr_phase,
  input  logic [31:0]            cfg_word,
  input  logic                   ctx_sel_valid,
  input  logic [1:0]             ctx_sel,
  input  logic                   rf_we,
  input  logic [RF_AW-1:0]       rf_addr,
  input  logic [31:0]            rf_wdata,
  output logic [31:0]            rf_rdata,
  output logic [1:0]             active_ctx,
  output logic                   cfg_err,
  output logic [DEPTH*32-1:0]    cfg_out
);
  logic             rst_s1_q, rst_s2_q, rst_i_n;
  logic             wr_en, wr_refused;
  ctx_t             wr_ctx, act;
  logic [IDX_W-1:0] wr_idx;
  logic [BUS_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  cfgstore_bus_fsm #(.PE_ID(PE_ID), .DEPTH(DEPTH)) u_bus (
    .clk(clk), .rst_n(rst_i_n),
    .bus_valid(cfg_valid), .bus_is_addr(cfg_addr_phase), .bus_word(cfg_word),
    .active_ctx(act),
    .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_refused(wr_refused)
  );

  cfgstore_ctx_ctrl u_ctx (
    .clk(clk), .rst_n(rst_i_n),
    .sel_valid(ctx_sel_valid), .sel_ctx(ctx_sel), .refused(wr_refused),
    .active_ctx(act), .err(cfg_err)
  );

  cfgstore_layers #(.DEPTH(DEPTH)) u_layers (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_idx(wr_idx), .wr_data(wr_data),
    .active_ctx(act), .cfg_flat(cfg_out)
  );

  cfgstore_rf_bank #(.RF_DEPTH(RF_DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_i_n),
    .bank(act), .we(rf_we), .addr(rf_addr), .wdata(rf_wdata), .rdata(rf_rdata)
  );

  assign active_ctx = act;

  // R11: background loading never disturbs the active configuration
  p_cfg_stable_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ctx_sel_valid |=> $stable(cfg_out));
endmodule

// File: tb/tb_ctx_config_store.sv
module tb_ctx_config_store;
  localparam int DEPTH = 8;
  localparam int RFD   = 4;
  localparam logic [7:0] ID = 8'h05;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_valid, cfg_addr_phase, ctx_sel_valid, rf_we;
  logic [31:0] cfg_word, rf_wdata, rf_rdata;
  logic [1:0] ctx_sel, active_ctx, rf_addr;
  logic cfg_err;
  logic [DEPTH*32-1:0] cfg_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_mem [4][DEPTH];
  logic [1:0]  exp_act;

  always #5 clk = ~clk;

  ctx_config_store #(.PE_ID(ID), .DEPTH(DEPTH), .RF_DEPTH(RFD)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_addr_phase(cfg_addr_phase),
    .cfg_word(cfg_word), .ctx_sel_valid(ctx_sel_valid), .ctx_sel(ctx_sel),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .active_ctx(active_ctx), .cfg_err(cfg_err), .cfg_out(cfg_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic is_addr, input logic [31:0] w);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr_phase = is_addr; cfg_word = w;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_addr_phase = 1'b0;
  endtask

  function automatic logic [31:0] aw(input logic [7:0] id, input logic [1:0] c, input logic [21:0] off);
    return {id, c, off};
  endfunction

  task automatic switch_to(input logic [1:0] c);
    @(negedge clk);
    ctx_sel_valid = 1'b1; ctx_sel = c;
    @(negedge clk);
    ctx_sel_valid = 1'b0;
    exp_act = c;
  endtask

  task automatic check_layer(input string req);
    chk(req, {30'd0, active_ctx}, {30'd0, exp_act});
    for (int w = 0; w < DEPTH; w++) chk(req, cfg_out[w*32 +: 32], exp_mem[exp_act][w]);
  endtask

  task automatic rf_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_addr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    rst_n = 1'b0; cfg_valid = 0; cfg_addr_phase = 0; cfg_word = 0;
    ctx_sel_valid = 0; ctx_sel = 0; rf_we = 0; rf_addr = 0; rf_wdata = 0;
    exp_act = 0;
    for (int c = 0; c < 4; c++) for (int w = 0; w < DEPTH; w++) exp_mem[c][w] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_layer("R1");
    chk("R1", {31'd0, cfg_err}, 32'd0);
    for (int a = 0; a < RFD; a++) begin
      rf_addr = a[1:0]; #1;
      chk("R1", rf_rdata, 32'd0);
    end

    // R2 / R11: load every word of idle contexts 1..3 while context 0 is active
    for (int c = 1; c < 4; c++) begin
      for (int w = 0; w < DEPTH; w++) begin
        logic [31:0] d;
        d = 32'hC0DE_0000 ^ (c << 12) ^ (w * 32'h0101_0011);
        send(1'b1, aw(ID, c[1:0], w[21:0]));
        send(1'b0, d);
        exp_mem[c][w] = d;
        for (int k = 0; k < DEPTH; k++) chk("R11", cfg_out[k*32 +: 32], 32'h0);
      end
    end
    // R7 / R2: visit each context
    for (int c = 0; c < 4; c++) begin
      switch_to(c[1:0]);
      check_layer("R7");
    end
    // R2: reload context 0 from context 3
    for (int w = 0; w < DEPTH; w++) begin
      send(1'b1, aw(ID, 2'd0, w[21:0]));
      send(1'b0, 32'h5A00_0000 + w);
      exp_mem[0][w] = 32'h5A00_0000 + w;
    end
    switch_to(2'd0);
    check_layer("R2");

    // R3 foreign identifier
    send(1'b1, aw(8'h06, 2'd1, 22'd2));
    send(1'b0, 32'hBAD0_0003);
    // R4 orphan data word, then a second data word after one address
    send(1'b0, 32'hBAD0_0004);
    send(1'b1, aw(ID, 2'd1, 22'd3));
    send(1'b0, 32'h1111_0003);
    send(1'b0, 32'hBAD0_0005);
    exp_mem[1][3] = 32'h1111_0003;
    // R5 offsets outside the depth
    send(1'b1, aw(ID, 2'd1, 22'(DEPTH)));
    send(1'b0, 32'hBAD0_0006);
    send(1'b1, aw(ID, 2'd1, 22'h3F_FFFF));
    send(1'b0, 32'hBAD0_0007);
    chk("R5", {31'd0, cfg_err}, 32'd0);
    // R10 the latest address word wins
    send(1'b1, aw(ID, 2'd2, 22'd4));
    send(1'b1, aw(ID, 2'd1, 22'd5));
    send(1'b0, 32'h2222_0005);
    exp_mem[1][5] = 32'h2222_0005;
    switch_to(2'd1);
    check_layer("R3_R4_R5");
    switch_to(2'd2);
    check_layer("R10");

    // R8 data word coincides with a switch to its own context
    send(1'b1, aw(ID, 2'd3, 22'd6));
    @(negedge clk);
    cfg_valid = 1; cfg_addr_phase = 0; cfg_word = 32'h3333_0006;
    ctx_sel_valid = 1; ctx_sel = 2'd3;
    @(negedge clk);
    cfg_valid = 0; ctx_sel_valid = 0;
    exp_act = 2'd3; exp_mem[3][6] = 32'h3333_0006;
    check_layer("R8");
    chk("R8", {31'd0, cfg_err}, 32'd0);

    // R9 banked register file
    for (int c = 0; c < 4; c++) begin
      switch_to(c[1:0]);
      for (int a = 0; a < RFD; a++) rf_write(a[1:0], 32'h7700_0000 + c * 16 + a);
    end
    for (int c = 3; c >= 0; c--) begin
      switch_to(c[1:0]);
      for (int a = 0; a < RFD; a++) begin
        rf_addr = a[1:0]; #1;
        chk("R9", rf_rdata, 32'h7700_0000 + c * 16 + a);
      end
    end

    // R6 write into the active context is refused and sticky
    switch_to(2'd3);
    snap = cfg_out[31:0];
    send(1'b1, aw(ID, 2'd3, 22'd0));
    send(1'b0, 32'hBAD0_0008);
    chk("R6", cfg_out[31:0], snap);
    chk("R6", {31'd0, cfg_err}, 32'd1);
    switch_to(2'd0);
    repeat (3) @(negedge clk);
    chk("R6", {31'd0, cfg_err}, 32'd1);
    check_layer("R6");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule